// File: doc/BRIEF.md
# Far-End Fault Signalling Engine

This block carries in-band far-end fault signalling for a 100 Mb/s fiber PHY. It works on the serial code-bit stream, one bit per clock. The fault pattern is a run of exactly 84 one bits closed by a single zero bit.

On the receive side, a run counter watches the incoming bits. A counter of back-to-back pattern occurrences raises a latching remote-fault status bit once three patterns arrive in a row. On the transmit side, the normal code-bit stream is replaced by a repeating fault pattern whenever the local receive link is down, so the partner learns that its transmissions are not being received.

Link state comes from a link-valid flag that the surrounding PHY asserts while valid link code words are arriving. No separate signal-detect input exists. Everything here acts only while fiber mode is enabled.

Top module: `fefi_engine`

## Requirements
- R1: A synchronous active-high reset clears the status bit, the run counter, the occurrence count and the transmit pattern position; after reset `tx_out` equals `tx_in`.
- R2: A zero bit on `rx_bit` that closes a run of exactly 84 ones counts as one pattern; the third back-to-back pattern sets `remote_fault` at the clock edge that samples its closing zero.
- R3: A zero that closes a run of any length other than 84 (83, 85 or more, or none) is not a pattern and clears the occurrence count.
- R4: Patterns must be consecutive; after a broken sequence, three fresh patterns are needed again.
- R5: `remote_fault` latches high and stays set until `rd_stb` is high at a clock edge that brings no new detection; it is then low after that edge.
- R6: A `rd_stb` at the same edge as a new detection leaves `remote_fault` set.
- R7: With `fiber_en` low, `remote_fault` is never set and `tx_out` equals `tx_in`.
- R8: With `fiber_en` high and `link_ok` low at a clock edge, `tx_out` from the next cycle on sends repeating 85-bit frames: 84 ones, then one zero.
- R9: When `link_ok` returns, the frame in progress is completed through its closing zero, and only then does `tx_out` follow `tx_in` again.
- R10: After a detection the occurrence count restarts, so a further detection needs three more patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| fiber_en | input | 1 | Fiber mode enable |
| link_ok | input | 1 | Local receive link valid |
| rx_bit | input | 1 | Received code bit |
| tx_in | input | 1 | Normal transmit code bit |
| rd_stb | input | 1 | Status read strobe; clears the status bit |
| tx_out | output | 1 | Transmit code bit to the line |
| remote_fault | output | 1 | Latched far-end fault status |

## Verification
Two events can land on the same clock edge: a status read and the closing zero of a third pattern. The bench raises `rd_stb` exactly in the cycle that carries that zero. It expects `remote_fault` to remain high, which shows that the new detection wins over the clear. In a separate case, a read with a zero that closes no pattern must clear the bit. A similar collision on the transmit side is provoked by restoring `link_ok` in the middle of a fault frame. The judgement there is that the closing zero still appears before `tx_in` is passed through.

// File: rtl/fefi_engine.sv
module fefi_engine #(
  parameter int RUN_LEN = 84,
  parameter int HITS    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic fiber_en,
  input  logic link_ok,
  input  logic rx_bit,
  input  logic tx_in,
  input  logic rd_stb,
  output logic tx_out,
  output logic remote_fault
);
  localparam int RW = $clog2(RUN_LEN + 2);
  localparam int HW = $clog2(HITS + 1);
  localparam int PW = $clog2(RUN_LEN + 1);
  localparam logic [RW-1:0] RUN_MAX = RW'(RUN_LEN + 1);

  logic [RW-1:0] ones;
  logic [HW-1:0] hits;
  logic [PW-1:0] pos;
  logic          sending;

  wire run_ok = ones == RW'(RUN_LEN);
  wire found  = fiber_en & ~rx_bit & run_ok & (hits == HW'(HITS - 1));
  wire frame_end = pos == PW'(RUN_LEN);

  always_ff @(posedge clk) begin
    if (rst || !fiber_en) begin
      ones <= '0;
      hits <= '0;
    end else if (rx_bit) begin
      if (ones != RUN_MAX) ones <= ones + RW'(1);
    end else begin
      ones <= '0;
      hits <= (run_ok && !found) ? hits + HW'(1) : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) remote_fault <= 1'b0;
    else     remote_fault <= fiber_en & (found | (remote_fault & ~rd_stb));
  end

  always_ff @(posedge clk) begin
    if (rst || !fiber_en) begin
      sending <= 1'b0;
      pos     <= '0;
    end else if (sending && !frame_end) begin
      pos <= pos + PW'(1);
    end else begin
      sending <= ~link_ok;
      pos     <= '0;
    end
  end

  assign tx_out = (sending && fiber_en) ? !frame_end : tx_in;

  a_r7_no_status_off_mode: assert property (@(posedge clk) disable iff (rst)
    !fiber_en |=> !remote_fault);
  a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
    rd_stb && !found |=> !remote_fault);
  a_r2_set_needs_zero: assert property (@(posedge clk) disable iff (rst)
    !remote_fault && rx_bit |=> !remote_fault);
  a_r8_start_on_loss: assert property (@(posedge clk) disable iff (rst)
    fiber_en && !link_ok && !sending |=> sending);
  a_r9_frame_completes: assert property (@(posedge clk) disable iff (rst)
    fiber_en && sending && !frame_end |=> sending || !fiber_en || rst);
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    ones <= RUN_MAX);
endmodule

// File: tb/test_fefi_engine.sv
module test_fefi_engine;
  logic clk = 1'b0;
  logic rst = 1'b1, fiber_en = 1'b1, link_ok = 1'b1, rx_bit = 1'b0, tx_in = 1'b0, rd_stb = 1'b0;
  logic tx_out, remote_fault;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fefi_engine i_fefi_engine (
    .clk(clk), .rst(rst), .fiber_en(fiber_en), .link_ok(link_ok), .rx_bit(rx_bit),
    .tx_in(tx_in), .rd_stb(rd_stb), .tx_out(tx_out), .remote_fault(remote_fault)
  );

  // {ones before the zero, read strobe during the zero, expected status after it}
  localparam int NV = 19;
  localparam logic [9:0] VEC [NV] = '{
    {8'd84, 1'b0, 1'b0}, {8'd84, 1'b0, 1'b0}, {8'd84, 1'b0, 1'b1},   // R2
    {8'd84, 1'b0, 1'b1}, {8'd10, 1'b1, 1'b0},                       // R5
    {8'd84, 1'b0, 1'b0}, {8'd83, 1'b0, 1'b0},                       // R3
    {8'd84, 1'b0, 1'b0}, {8'd84, 1'b0, 1'b0}, {8'd85, 1'b0, 1'b0},   // R3 R4
    {8'd84, 1'b0, 1'b0}, {8'd84, 1'b0, 1'b0}, {8'd0,  1'b0, 1'b0},   // R4
    {8'd84, 1'b0, 1'b0}, {8'd84, 1'b0, 1'b0}, {8'd84, 1'b1, 1'b1},   // R6
    {8'd84, 1'b1, 1'b0}, {8'd84, 1'b0, 1'b0}, {8'd84, 1'b0, 1'b1}    // R10
  };

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input logic b, input logic rd);
    @(negedge clk);
    rx_bit = b;
    rd_stb = rd;
    @(posedge clk);
    #1;
  endtask

  task automatic pattern(input int n, input logic rd);
    for (int k = 0; k < n; k++) step(1'b1, 1'b0);
    step(1'b0, rd);
    rd_stb = 1'b0;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 status after reset", remote_fault, 1'b0);
        tx_in = 1'b1; #0.5;
        check("R1 tx pass high", tx_out, 1'b1);
        tx_in = 1'b0; #0.5;
        check("R1 tx pass low", tx_out, 1'b0);

        for (int v = 0; v < NV; v++) begin
          pattern(int'(VEC[v][9:2]), VEC[v][1]);
          check($sformatf("R2-R6/R10 vector %0d", v), remote_fault, VEC[v][0]);
        end

        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 reset clears status", remote_fault, 1'b0);
        pattern(84, 1'b0); pattern(84, 1'b0);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        pattern(84, 1'b0);
        check("R1 reset clears occurrence count", remote_fault, 1'b0);

        fiber_en = 1'b0;
        for (int k = 0; k < 3; k++) pattern(84, 1'b0);
        check("R7 no status outside fiber mode", remote_fault, 1'b0);
        link_ok = 1'b0;
        repeat (4) @(negedge clk);
        tx_in = 1'b1; #0.5;
        check("R7 tx pass high", tx_out, 1'b1);
        tx_in = 1'b0; #0.5;
        check("R7 tx pass low", tx_out, 1'b0);

        link_ok = 1'b1;
        fiber_en = 1'b1;
        repeat (2) @(negedge clk);
        link_ok = 1'b0;
        @(posedge clk); #1;
        for (int j = 0; j < 300; j++) begin
          logic e;
          if (j < 255) e = (j % 85) != 84;
          else e = tx_in;
          check(j < 190 ? "R8 fault frame bit" : "R9 finish frame", tx_out, e);
          @(negedge clk);
          if (j == 189) link_ok = 1'b1;
          @(posedge clk); #1;
        end
        done = 1'b1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          total++; bad++;
          $display("FAIL watchdog: got hang expected completion");
        end
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule